// File: doc/BRIEF.md
# Majority-Vote Serial Byte Receiver

This block takes an asynchronous serial line carrying frames of one start bit, eight data bits and one stop bit (no parity), and turns them into bytes queued for a reader. The line is captured only on the clock edges where `sample_tick` is high. That tick runs at four times the bit rate and is supplied from outside. The captured values pass through a four-stage shift register, which acts both as the synchroniser and as the oversampling window. Every bit is settled by a vote over the four samples that fall inside it.

A small sequencer waits in `RX_IDLE` until a low sample reaches the newest stage of the window. It moves to `RX_START` to confirm the start bit, then to `RX_DATA` for eight bits taken least significant first, and then to `RX_STOP`. At the stop decision the assembled byte goes into a 16-entry queue, which is built from two 4-bit storage lanes. The reader sees the oldest byte on `rd_data` and removes it with `rd_en`.

The transitions are named as follows. IDLE→START is *trigger*. START→IDLE is *reject*. START→DATA is *confirm*. DATA→DATA is *next bit*. DATA→STOP is *last bit*. STOP→IDLE is *deliver*. Two sticky flags, cleared only by reset, report a bad stop bit and a byte lost to a full queue.

Top module: `uart_mv_rx`

## Requirements
- R1: `rx_line` is captured only at rising clock edges with `sample_tick` high, into a 4-stage window, with the newest value in stage 0. A low pulse that covers no such edge has no effect, and no byte is stored.
- R2: In `RX_IDLE`, a 0 in the newest stage triggers a frame. Once the three following samples are in, the vote over the four start samples is taken. If it is 1, the frame is rejected, the block returns to `RX_IDLE` and nothing is stored. A single low sample or two low samples are rejected in this way.
- R3: Each vote is 1 when three or four of the samples in the window are 1, and 0 when at most one is 1.
- R4: A 2-versus-2 vote takes the value of the last decided bit of any kind (start, data or stop). That value is 1 after reset.
- R5: The eight data bits follow the start bit at four samples each. They are assembled least significant bit first.
- R6: When the stop bit is decided, the byte is written into the queue. `empty` falls no later than two clock cycles after the tick edge that captured the fourth stop sample.
- R7: A stop vote of 0 sets `frame_err`, which stays at 1 until reset. The byte is still stored.
- R8: The queue holds 16 bytes and returns them oldest first. `rd_data` shows the oldest byte while `empty` is 0, and `rd_en` removes it. `rd_en` has no effect while `empty` is 1. `empty` and `full` are never high together.
- R9: A byte that arrives while `full` is 1 is discarded, and `overrun` is set and stays at 1 until reset. The 16 stored bytes are left unchanged.
- R10: After reset, `empty` is 1 and `full`, `frame_err` and `overrun` are 0.
- R11: A start bit may follow the stop bit directly, with no idle samples between frames, and both bytes are received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle strobe at four times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Remove the oldest byte from the queue |
| rd_data | output | 8 | Oldest queued byte |
| empty | output | 1 | Queue holds no byte |
| full | output | 1 | Queue holds 16 bytes |
| frame_err | output | 1 | Sticky: a stop bit was voted 0 |
| overrun | output | 1 | Sticky: a byte was dropped because the queue was full |

## Verification
The bench sends frames built sample by sample. Some bits carry one wrong sample, and a design that took a single sample instead of the vote would decode the wrong byte. Other bits are split two against two. Those are expected to follow the last decided bit in both polarities, so a fixed tie value would flip one of them. Short low glitches of one and two samples, and a one-clock pulse between ticks, must leave the queue empty. A sequencer that skipped the start confirmation, or that sampled between ticks, would store a spurious byte. The queue is also filled to 16 and then sent one byte more. A design that overwrote the oldest entry, or let a pointer wrap, would show up when the queue is drained. A frame with a low stop bit must still be stored and must leave `frame_err` set across a later good frame.

// File: rtl/uart_mv_pkg.sv
`timescale 1ns/1ps
package uart_mv_pkg;

    // Frame sequencer states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/uart_mv_sampler.sv
`timescale 1ns/1ps
// Captures the line on each sample tick into a shift window (stage 0 newest)
// and reports how many window stages hold a 1.
module uart_mv_sampler #(
    parameter int SAMPLES = 4,
    localparam int CNT_W = $clog2(SAMPLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_tick,
    input  logic               rx_line,
    output logic               stb,
    output logic               newest,
    output logic [CNT_W-1:0]   ones
);

    logic [SAMPLES-1:0] window_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            window_q <= '1;
            stb      <= 1'b0;
        end else begin
            stb <= sample_tick;
            if (sample_tick) begin
                window_q <= {window_q[SAMPLES-2:0], rx_line};
            end
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < SAMPLES; i++) begin
            ones = ones + CNT_W'(window_q[i]);
        end
    end

    assign newest = window_q[0];

endmodule

// File: rtl/uart_mv_framer.sv
`timescale 1ns/1ps
// Frame sequencer: start trigger and confirmation, data bits LSB first, stop decision.
module uart_mv_framer
    import uart_mv_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SAMPLES = 4,
    localparam int CNT_W = $clog2(SAMPLES + 1),
    localparam int PH_W  = $clog2(SAMPLES),
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              newest,
    input  logic [CNT_W-1:0]  ones,
    output logic              push,
    output logic [DATA_W-1:0] byte_out,
    output logic              stop_ok
);

    localparam logic [CNT_W-1:0] HALF      = CNT_W'(SAMPLES / 2);
    localparam logic [PH_W-1:0]  PH_CONF   = PH_W'(SAMPLES - 2);
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(SAMPLES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

    rx_state_e          state_q, state_d;
    logic [PH_W-1:0]    phase_q;
    logic [BIT_W-1:0]   bit_q;
    logic [DATA_W-1:0]  shreg_q;
    logic               prev_q;
    logic               vote;
    logic               decide;

    // vote with tie resolved to the last decided bit
    always_comb begin
        if (ones > HALF)      vote = 1'b1;
        else if (ones < HALF) vote = 1'b0;
        else                  vote = prev_q;
    end

    always_comb begin
        unique case (state_q)
            RX_IDLE:  decide = 1'b0;
            RX_START: decide = stb && (phase_q == PH_CONF);
            RX_DATA,
            RX_STOP:  decide = stb && (phase_q == PH_LAST);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (stb && !newest) state_d = RX_START;           // trigger
            RX_START: if (decide) state_d = vote ? RX_IDLE : RX_DATA;   // reject / confirm
            RX_DATA:  if (decide && bit_q == BIT_LAST) state_d = RX_STOP; // last bit
            RX_STOP:  if (decide) state_d = RX_IDLE;                     // deliver
        endcase
    end

    // sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            prev_q  <= 1'b1;
        end else if (stb) begin
            if (state_q == RX_IDLE || decide) phase_q <= '0;
            else                              phase_q <= phase_q + 1'b1;
            if (state_q == RX_IDLE)           bit_q <= '0;
            else if (decide && state_q == RX_DATA) begin
                bit_q   <= bit_q + 1'b1;
                shreg_q <= {vote, shreg_q[DATA_W-1:1]};
            end
            if (decide) prev_q <= vote;
        end
    end

    // outputs
    always_comb begin
        push     = decide && (state_q == RX_STOP);
        byte_out = shreg_q;
        stop_ok  = vote;
    end

endmodule

// File: rtl/uart_mv_fifo.sv
`timescale 1ns/1ps
// Show-ahead queue stored as parallel narrow lanes.
module uart_mv_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int LANE_W = 4,
    localparam int LANES = DATA_W / LANE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);

    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [AW:0]   count_q;
    logic          do_wr, do_rd;

    assign empty = (count_q == '0);
    assign full  = (count_q == (AW+1)'(DEPTH));
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (do_wr) mem[wr_ptr_q] <= wr_data[l*LANE_W +: LANE_W];
        end
        assign rd_data[l*LANE_W +: LANE_W] = mem[rd_ptr_q];
    end

endmodule

// File: rtl/uart_mv_rx.sv
`timescale 1ns/1ps
module uart_mv_rx #(
    parameter int DATA_W  = 8,
    parameter int SAMPLES = 4,
    parameter int DEPTH   = 16,
    parameter int LANE_W  = 4,
    localparam int CNT_W = $clog2(SAMPLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              rx_line,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              frame_err,
    output logic              overrun
);

    logic              stb;
    logic              newest;
    logic [CNT_W-1:0]  ones;
    logic              push;
    logic [DATA_W-1:0] rx_byte;
    logic              stop_ok;

    uart_mv_sampler #(.SAMPLES(SAMPLES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
        .stb(stb), .newest(newest), .ones(ones)
    );

    uart_mv_framer #(.DATA_W(DATA_W), .SAMPLES(SAMPLES)) u_framer (
        .clk(clk), .rst_n(rst_n), .stb(stb), .newest(newest), .ones(ones),
        .push(push), .byte_out(rx_byte), .stop_ok(stop_ok)
    );

    uart_mv_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANE_W(LANE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(rx_byte),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (push && !stop_ok) frame_err <= 1'b1;
            if (push && full)     overrun   <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_mv_rx_chk.sv
`timescale 1ns/1ps
module uart_mv_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic sample_tick,
    input logic rd_en,
    input logic empty,
    input logic full,
    input logic frame_err,
    input logic overrun,
    input logic push,
    input logic stop_ok
);

    // R8
    not_empty_and_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R8
    quiet_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !rd_en) |=> ($stable(empty) && $stable(full)));

    // R8
    pop_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !push) |=> empty);

    // R6
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty);

    // R1
    push_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(sample_tick));

    // R7
    frame_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !stop_ok) |=> frame_err);

    // R7
    frame_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> overrun);

    // R9
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind uart_mv_rx uart_mv_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rd_en(rd_en),
    .empty(empty), .full(full), .frame_err(frame_err), .overrun(overrun),
    .push(push), .stop_ok(stop_ok)
);

// File: tb/uart_mv_rx_tb.sv
`timescale 1ns/1ps
module uart_mv_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       empty, full, frame_err, overrun;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // tick high for one clock in four, changed away from the active edge
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 4;
        sample_tick = (tcnt == 0);
    end

    uart_mv_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
        .frame_err(frame_err), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_line = 1'b1; rd_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // hold one value across exactly one tick edge; returns at a negedge
    task automatic send_sample(input logic b);
        rx_line = b;
        @(posedge clk);
        while (!sample_tick) @(posedge clk);
        @(negedge clk);
    endtask

    // four samples, bit 3 first
    task automatic send_four(input logic [3:0] s);
        for (int i = 3; i >= 0; i--) send_sample(s[i]);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stopv, input int idle);
        send_four(4'b0000);
        for (int i = 0; i < 8; i++) send_four({4{b[i]}});
        send_four({4{stopv}});
        for (int i = 0; i < idle; i++) send_sample(1'b1);
    endtask

    task automatic pop_check(input logic [7:0] exp, input string req);
        chk(!empty, req, empty, 0);
        chk(rd_data == exp, req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(empty == 1'b1, "R10", empty, 1);
        chk(full == 1'b0, "R10", full, 0);
        chk(frame_err == 1'b0, "R10", frame_err, 0);
        chk(overrun == 1'b0, "R10", overrun, 0);
    endtask

    task automatic t_back_to_back();
        do_reset();
        send_frame(8'hA5, 1'b1, 0);   // R11: no idle between frames
        send_frame(8'h3C, 1'b1, 0);
        send_frame(8'h01, 1'b1, 2);
        pop_check(8'hA5, "R5");
        pop_check(8'h3C, "R11");
        pop_check(8'h01, "R8");
        chk(empty == 1'b1, "R8", empty, 1);
        chk(frame_err == 1'b0, "R7", frame_err, 0);
    endtask

    task automatic t_latency();
        do_reset();
        send_frame(8'h42, 1'b1, 0);
        // fourth stop sample captured at the last tick edge; allow two clocks
        @(negedge clk);
        @(negedge clk);
        chk(empty == 1'b0, "R6", empty, 0);
        pop_check(8'h42, "R6");
    endtask

    task automatic t_between_ticks();
        do_reset();
        send_sample(1'b1);
        rx_line = 1'b0;            // low for one clock, no tick edge inside
        @(negedge clk);
        rx_line = 1'b1;
        for (int i = 0; i < 44; i++) send_sample(1'b1);
        chk(empty == 1'b1, "R1", empty, 1);
        send_frame(8'hC3, 1'b1, 2);
        pop_check(8'hC3, "R1");
    endtask

    task automatic t_false_start();
        do_reset();
        send_sample(1'b0);
        for (int i = 0; i < 44; i++) send_sample(1'b1);
        chk(empty == 1'b1, "R2", empty, 1);
        send_sample(1'b0);          // R4: two lows tie, previous bit 1 rejects
        send_sample(1'b0);
        for (int i = 0; i < 44; i++) send_sample(1'b1);
        chk(empty == 1'b1, "R4", empty, 1);
        send_frame(8'h81, 1'b1, 2);
        pop_check(8'h81, "R2");
        chk(empty == 1'b1, "R2", empty, 1);
    endtask

    task automatic t_vote();
        logic [7:0] b = 8'h96;
        do_reset();
        send_four(4'b0010);                     // start with one high sample
        for (int i = 0; i < 8; i++)
            send_four({4{b[i]}} ^ (4'b1000 >> (i % 4)));
        send_four(4'b1011);
        send_sample(1'b1);
        send_sample(1'b1);
        pop_check(8'h96, "R3");
    endtask

    task automatic t_tie();
        do_reset();
        send_four(4'b0000);
        send_four(4'b1111);  // b0 = 1
        send_four(4'b1100);  // b1 tie -> 1
        send_four(4'b0000);  // b2 = 0
        send_four(4'b0011);  // b3 tie -> 0
        send_four(4'b1111);  // b4 = 1
        send_four(4'b0011);  // b5 tie -> 1
        send_four(4'b0000);  // b6 = 0
        send_four(4'b1100);  // b7 tie -> 0
        send_four(4'b1111);
        send_sample(1'b1);
        send_sample(1'b1);
        pop_check(8'h33, "R4");
    endtask

    task automatic t_framing();
        do_reset();
        send_frame(8'h5A, 1'b0, 3);
        chk(frame_err == 1'b1, "R7", frame_err, 1);
        pop_check(8'h5A, "R7");
        send_frame(8'h7E, 1'b1, 2);
        pop_check(8'h7E, "R7");
        chk(frame_err == 1'b1, "R7", frame_err, 1);
    endtask

    task automatic t_overrun();
        do_reset();
        rd_en = 1'b1;                // pop on empty has no effect
        @(negedge clk);
        rd_en = 1'b0;
        chk(empty == 1'b1, "R8", empty, 1);
        for (int i = 0; i < 16; i++) send_frame(8'(i * 7 + 1), 1'b1, 1);
        chk(full == 1'b1, "R8", full, 1);
        chk(overrun == 1'b0, "R9", overrun, 0);
        send_frame(8'hEE, 1'b1, 2);
        chk(overrun == 1'b1, "R9", overrun, 1);
        chk(full == 1'b1, "R9", full, 1);
        for (int i = 0; i < 16; i++) pop_check(8'(i * 7 + 1), "R9");
        chk(empty == 1'b1, "R9", empty, 1);
        chk(overrun == 1'b1, "R9", overrun, 1);
    endtask

    initial begin
        t_reset();
        t_back_to_back();
        t_latency();
        t_between_ticks();
        t_false_start();
        t_vote();
        t_tie();
        t_framing();
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule